// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a small programmable logic element for a microcontroller peripheral fabric. Sixteen single-bit signals enter a bank of four gate lines. Each line ORs together any chosen subset of the inputs, and each input can be taken true or complemented. Each line then has its own inversion bit. The four lines feed one of eight functions, chosen by a 3-bit mode field. Three of these functions are combinational. The other five are storage elements, each emulated with one state register clocked by the system clock.

The function result is forced low while the cell is disabled. Otherwise it is XORed with a polarity bit and registered once on the system clock. That registered value is the peripheral output. It also drives the pin output when pin output is enabled. An edge detector watches the registered output and can raise a sticky interrupt flag on a rising edge, a falling edge, or both. A one-cycle clear pulse drops the flag. All configuration arrives as static inputs.

The storage element has two states, ST_CLR and ST_SET. The clear transitions, the set transitions, the edge-load transitions and the hold transition of each storage mode are listed in R5 to R9. The interrupt flag has two states. The transition FLAG_IDLE to FLAG_PEND is taken on an enabled edge. The transition FLAG_PEND to FLAG_IDLE is taken on a clear pulse with no enabled edge in the same cycle. Any other case holds the current state.

Top module: `cfg_logic_cell`

## Requirements
- R1: Gate line i (i = 0..3; line 0 is g1, line 3 is g4) is the OR of data_in[k] over every k where sel_true[16*i+k] is 1, ORed with ~data_in[k] over every k where sel_comp[16*i+k] is 1, then XORed with line_inv[i]; a line with no selection is 0 before inversion.
- R2: Mode 3'b000 gives (g1 & g2) | (g3 & g4).
- R3: Mode 3'b001 gives (g1 | g2) ^ (g3 | g4).
- R4: Mode 3'b010 gives g1 & g2 & g3 & g4.
- R5: Mode 3'b011 is a set/reset latch with set = g1|g2 and reset = g3|g4. Reset moves it to ST_CLR and wins over set. Set alone moves it to ST_SET. With neither asserted it holds.
- R6: Mode 3'b100 is a D flip-flop that loads g2 on a rising g1. Reset g3 and set g4 act at level without a clock edge, and reset wins over set.
- R7: Mode 3'b101 is a D flip-flop that loads g2|g4 on a rising g1. Reset g3 acts at level and wins over the load.
- R8: Mode 3'b110 is a J-K flip-flop clocked by a rising g1, with J = g2 and K = g4. J alone sets it, K alone clears it, both together toggle it, and neither holds it. Reset g3 acts at level and wins.
- R9: Mode 3'b111 is a transparent latch that follows g2 while g3 is 0 and holds while g3 is 1. Reset g1 and set g4 act at level, and reset wins over set.
- R10: While cell_en is 1 the peripheral output is the function result XOR out_pol. While cell_en is 0 the output is 0 whatever out_pol is, and the storage element is held in ST_CLR.
- R11: pin_out equals periph_out while pin_oe is 1 and is 0 while pin_oe is 0.
- R12: periph_out reflects a change at data_in one clock edge later in the combinational modes. A storage element captures at the first clock edge where its control is seen, and periph_out follows one edge after that.
- R13: irq_flag is set one clock after periph_out rises when irq_pos_en is 1, and one clock after it falls when irq_neg_en is 1. It stays set until an irq_clr pulse. A set in the same cycle as irq_clr wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | 16 | Input signals to the gate bank |
| sel_true | input | 64 | Selects each input in true form, per gate line (16 bits per line) |
| sel_comp | input | 64 | Selects each input in complemented form, per gate line |
| line_inv | input | 4 | Inversion bit per gate line |
| mode | input | 3 | Function select |
| cell_en | input | 1 | Cell enable |
| out_pol | input | 1 | Output polarity inversion |
| pin_oe | input | 1 | Pin output enable |
| irq_pos_en | input | 1 | Rising-edge interrupt enable |
| irq_neg_en | input | 1 | Falling-edge interrupt enable |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| periph_out | output | 1 | Registered cell output to peripherals |
| pin_out | output | 1 | Cell output gated by pin_oe |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench steps every combinational mode through all sixteen line patterns. It drives each storage mode with set and reset together, so a design with the priority reversed would leave the output high where it must be low. In the edge-clocked modes it moves D while the clock line is held high, so a flop that loads on level and not on the edge would follow D. It also sets the toggle case of the J-K twice, and a flop that does not toggle would stay fixed. Further checks cover polarity with the cell disabled, where a design that inverts after the enable would drive 1. The last check fires a clear pulse in the same cycle as a rising edge, where a design that lets the clear win would drop the flag.

// File: rtl/clc_pkg.sv
package clc_pkg;

    localparam int CLC_LINES = 4;

    typedef enum logic [2:0] {
        MODE_AND_OR = 3'b000,
        MODE_OR_XOR = 3'b001,
        MODE_AND4   = 3'b010,
        MODE_SR     = 3'b011,
        MODE_DFF_SR = 3'b100,
        MODE_DFF_R  = 3'b101,
        MODE_JK     = 3'b110,
        MODE_TLAT   = 3'b111
    } clc_mode_t;

    typedef enum logic {
        ST_CLR = 1'b0,
        ST_SET = 1'b1
    } store_state_t;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_t;

endpackage

// File: rtl/clc_gate_bank.sv
module clc_gate_bank #(
    parameter int N_IN    = 16,
    parameter int N_LINES = 4
) (
    input  logic [N_IN-1:0]         data_in,
    input  logic [N_LINES*N_IN-1:0] sel_true,
    input  logic [N_LINES*N_IN-1:0] sel_comp,
    input  logic [N_LINES-1:0]      line_inv,
    output logic [N_LINES-1:0]      lines
);

    generate
        for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
            logic hit_true;
            logic hit_comp;
            assign hit_true  = |(data_in & sel_true[gi*N_IN +: N_IN]);
            assign hit_comp  = |(~data_in & sel_comp[gi*N_IN +: N_IN]);
            assign lines[gi] = (hit_true | hit_comp) ^ line_inv[gi];
        end
    endgenerate

endmodule

// File: rtl/clc_func_unit.sv
module clc_func_unit
    import clc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cell_en,
    input  clc_mode_t            mode,
    input  logic [CLC_LINES-1:0] lines,
    output logic                 func_out
);

    logic g1, g2, g3, g4;
    logic g1_prev;
    logic g1_rise;
    store_state_t st_q, st_d;

    assign g1 = lines[0];
    assign g2 = lines[1];
    assign g3 = lines[2];
    assign g4 = lines[3];

    assign g1_rise = g1 & ~g1_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_CLR;
            g1_prev <= 1'b0;
        end else begin
            st_q    <= st_d;
            g1_prev <= g1;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!cell_en) begin
            st_d = ST_CLR;
        end else begin
            unique case (mode)
                MODE_SR: begin
                    if (g3 | g4)      st_d = ST_CLR;
                    else if (g1 | g2) st_d = ST_SET;
                end
                MODE_DFF_SR: begin
                    if (g3)           st_d = ST_CLR;
                    else if (g4)      st_d = ST_SET;
                    else if (g1_rise) st_d = g2 ? ST_SET : ST_CLR;
                end
                MODE_DFF_R: begin
                    if (g3)           st_d = ST_CLR;
                    else if (g1_rise) st_d = (g2 | g4) ? ST_SET : ST_CLR;
                end
                MODE_JK: begin
                    if (g3) begin
                        st_d = ST_CLR;
                    end else if (g1_rise) begin
                        unique case ({g2, g4})
                            2'b10:   st_d = ST_SET;
                            2'b01:   st_d = ST_CLR;
                            2'b11:   st_d = (st_q == ST_SET) ? ST_CLR : ST_SET;
                            default: st_d = st_q;
                        endcase
                    end
                end
                MODE_TLAT: begin
                    if (g1)           st_d = ST_CLR;
                    else if (g4)      st_d = ST_SET;
                    else if (!g3)     st_d = g2 ? ST_SET : ST_CLR;
                end
                default: st_d = st_q;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (mode)
            MODE_AND_OR: func_out = (g1 & g2) | (g3 & g4);
            MODE_OR_XOR: func_out = (g1 | g2) ^ (g3 | g4);
            MODE_AND4:   func_out = g1 & g2 & g3 & g4;
            default:     func_out = (st_q == ST_SET);
        endcase
    end

endmodule

// File: rtl/clc_irq_unit.sv
module clc_irq_unit
    import clc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cell_out,
    input  logic pos_en,
    input  logic neg_en,
    input  logic clr,
    output logic sync_out,
    output logic flag
);

    logic        out_prev;
    logic        edge_hit;
    flag_state_t fl_q, fl_d;

    assign edge_hit = (pos_en & sync_out & ~out_prev) |
                      (neg_en & ~sync_out & out_prev);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_out <= 1'b0;
            out_prev <= 1'b0;
            fl_q     <= FLAG_IDLE;
        end else begin
            sync_out <= cell_out;
            out_prev <= sync_out;
            fl_q     <= fl_d;
        end
    end

    // next-state logic
    always_comb begin
        fl_d = fl_q;
        unique case (fl_q)
            FLAG_IDLE: if (edge_hit)         fl_d = FLAG_PEND;
            FLAG_PEND: if (clr && !edge_hit) fl_d = FLAG_IDLE;
            default:   fl_d = FLAG_IDLE;
        endcase
    end

    // output logic
    assign flag = (fl_q == FLAG_PEND);

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import clc_pkg::*;
#(
    parameter int N_IN = 16,
    localparam int SEL_W = CLC_LINES * N_IN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      data_in,
    input  logic [SEL_W-1:0]     sel_true,
    input  logic [SEL_W-1:0]     sel_comp,
    input  logic [CLC_LINES-1:0] line_inv,
    input  logic [2:0]           mode,
    input  logic                 cell_en,
    input  logic                 out_pol,
    input  logic                 pin_oe,
    input  logic                 irq_pos_en,
    input  logic                 irq_neg_en,
    input  logic                 irq_clr,
    output logic                 periph_out,
    output logic                 pin_out,
    output logic                 irq_flag
);

    logic [CLC_LINES-1:0] lines;
    logic                 func_out;
    logic                 cell_out;
    logic                 sync_out;

    clc_gate_bank #(
        .N_IN    (N_IN),
        .N_LINES (CLC_LINES)
    ) u_gates (
        .data_in  (data_in),
        .sel_true (sel_true),
        .sel_comp (sel_comp),
        .line_inv (line_inv),
        .lines    (lines)
    );

    clc_func_unit u_func (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_en  (cell_en),
        .mode     (clc_mode_t'(mode)),
        .lines    (lines),
        .func_out (func_out)
    );

    assign cell_out = cell_en & (func_out ^ out_pol);

    clc_irq_unit u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cell_out (cell_out),
        .pos_en   (irq_pos_en),
        .neg_en   (irq_neg_en),
        .clr      (irq_clr),
        .sync_out (sync_out),
        .flag     (irq_flag)
    );

    assign periph_out = sync_out;
    assign pin_out    = sync_out & pin_oe;

endmodule

// File: rtl/clc_checker.sv
module clc_checker (
    input logic clk,
    input logic rst_n,
    input logic cell_en,
    input logic irq_pos_en,
    input logic irq_neg_en,
    input logic irq_clr,
    input logic periph_out,
    input logic pin_out,
    input logic irq_flag
);

    assert_disabled_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |=> !periph_out);

    assert_pin_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |=> !pin_out);

    assert_rise_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pos_en && $rose(periph_out)) |=> irq_flag);

    assert_fall_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_neg_en && $fell(periph_out)) |=> irq_flag);

    assert_flag_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

    assert_flag_clears_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !$rose(periph_out) && !$fell(periph_out)) |=> !irq_flag);

endmodule

bind cfg_logic_cell clc_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_en    (cell_en),
    .irq_pos_en (irq_pos_en),
    .irq_neg_en (irq_neg_en),
    .irq_clr    (irq_clr),
    .periph_out (periph_out),
    .pin_out    (pin_out),
    .irq_flag   (irq_flag)
);

// File: tb/cfg_logic_cell_tb_top.sv
module cfg_logic_cell_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] data_in = '0;
    logic [63:0] sel_true = '0;
    logic [63:0] sel_comp = '0;
    logic [3:0]  line_inv = '0;
    logic [2:0]  mode = '0;
    logic        cell_en = 1'b0;
    logic        out_pol = 1'b0;
    logic        pin_oe = 1'b0;
    logic        irq_pos_en = 1'b0;
    logic        irq_neg_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        periph_out;
    logic        pin_out;
    logic        irq_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    cfg_logic_cell dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_in    (data_in),
        .sel_true   (sel_true),
        .sel_comp   (sel_comp),
        .line_inv   (line_inv),
        .mode       (mode),
        .cell_en    (cell_en),
        .out_pol    (out_pol),
        .pin_oe     (pin_oe),
        .irq_pos_en (irq_pos_en),
        .irq_neg_en (irq_neg_en),
        .irq_clr    (irq_clr),
        .periph_out (periph_out),
        .pin_out    (pin_out),
        .irq_flag   (irq_flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // lines g1..g4 follow data_in[0..3]
    task automatic gates_direct();
        sel_true = '0;
        sel_true[0]  = 1'b1;
        sel_true[17] = 1'b1;
        sel_true[34] = 1'b1;
        sel_true[51] = 1'b1;
        sel_comp = '0;
        line_inv = 4'b0000;
    endtask

    // mode AND4 with lines 2..4 unselected and inverted: output = data_in[0]
    task automatic gates_follow_d0();
        sel_true = 64'h1;
        sel_comp = '0;
        line_inv = 4'b1110;
        mode     = 3'b010;
    endtask

    task automatic clear_store();
        cell_en = 1'b0;
        step(2);
        cell_en = 1'b1;
    endtask

    function automatic logic comb_exp(input int m, input logic [3:0] d);
        case (m)
            0:       return (d[0] & d[1]) | (d[2] & d[3]);
            1:       return (d[0] | d[1]) ^ (d[2] | d[3]);
            default: return &d;
        endcase
    endfunction

    task automatic t_reset();
        chk("R10 reset periph_out", periph_out, 1'b0);
        chk("R11 reset pin_out", pin_out, 1'b0);
        chk("R13 reset irq_flag", irq_flag, 1'b0);
    endtask

    task automatic t_gates_R1();
        cell_en = 1'b1;
        mode = 3'b010;
        sel_true = 64'h0; sel_true[5] = 1'b1;
        sel_comp = 64'h0; sel_comp[9] = 1'b1;
        line_inv = 4'b1110;
        data_in = 16'h0000; step(1);
        chk("R1 complement term", periph_out, 1'b1);
        data_in = 16'h0200; step(1);
        chk("R1 no term true", periph_out, 1'b0);
        data_in = 16'h0220; step(1);
        chk("R1 true term", periph_out, 1'b1);
        sel_true = '0; sel_comp = '0; line_inv = 4'b1111; step(1);
        chk("R1 empty line inverted", periph_out, 1'b1);
        line_inv = 4'b1110; step(1);
        chk("R1 empty line is 0", periph_out, 1'b0);
        data_in = '0;
    endtask

    task automatic t_comb(input int m, input string tag);
        cell_en = 1'b1;
        gates_direct();
        mode = 3'(m);
        for (int v = 0; v < 16; v++) begin
            data_in = 16'(v);
            step(1);
            chk(tag, periph_out, comb_exp(m, 4'(v)));
        end
        data_in = '0;
        step(1);
    endtask

    task automatic t_latency_R12();
        cell_en = 1'b1;
        gates_follow_d0();
        data_in = 16'h0000; step(2);
        data_in = 16'h0001;
        #0.5;
        chk("R12 before edge unchanged", periph_out, 1'b0);
        step(1);
        chk("R12 after one edge", periph_out, 1'b1);
        data_in = '0; step(1);
        chk("R12 falls after one edge", periph_out, 1'b0);
    endtask

    task automatic t_sr_R5();
        gates_direct(); mode = 3'b011; clear_store();
        data_in = 16'h0000; step(2); chk("R5 starts clear", periph_out, 1'b0);
        data_in = 16'h0001; step(2); chk("R5 set by g1", periph_out, 1'b1);
        data_in = 16'h0000; step(2); chk("R5 hold", periph_out, 1'b1);
        data_in = 16'h0004; step(2); chk("R5 reset by g3", periph_out, 1'b0);
        data_in = 16'h0002; step(2); chk("R5 set by g2", periph_out, 1'b1);
        data_in = 16'h0009; step(2); chk("R5 reset wins", periph_out, 1'b0);
        data_in = 16'h0000;
    endtask

    task automatic t_dff_R6();
        gates_direct(); mode = 3'b100; clear_store();
        data_in = 16'h0002; step(2); chk("R6 no edge no load", periph_out, 1'b0);
        data_in = 16'h0003; step(2); chk("R6 load on g1 rise", periph_out, 1'b1);
        data_in = 16'h0001; step(2); chk("R6 D moves with g1 high", periph_out, 1'b1);
        data_in = 16'h0000; step(2); chk("R6 hold", periph_out, 1'b1);
        data_in = 16'h0004; step(2); chk("R6 level reset", periph_out, 1'b0);
        data_in = 16'h0008; step(2); chk("R6 level set", periph_out, 1'b1);
        data_in = 16'h000C; step(2); chk("R6 reset wins", periph_out, 1'b0);
        data_in = 16'h0000;
    endtask

    task automatic t_dffr_R7();
        gates_direct(); mode = 3'b101; clear_store();
        data_in = 16'h0000; step(2);
        data_in = 16'h0009; step(2); chk("R7 load g4 path", periph_out, 1'b1);
        data_in = 16'h0000; step(2); chk("R7 hold", periph_out, 1'b1);
        data_in = 16'h0001; step(2); chk("R7 load zero", periph_out, 1'b0);
        data_in = 16'h0000; step(1);
        data_in = 16'h0003; step(2); chk("R7 load g2 path", periph_out, 1'b1);
        data_in = 16'h0004; step(2); chk("R7 reset", periph_out, 1'b0);
        data_in = 16'h0000; step(1);
        data_in = 16'h0007; step(2); chk("R7 reset wins over load", periph_out, 1'b0);
        data_in = 16'h0000;
    endtask

    task automatic t_jk_R8();
        gates_direct(); mode = 3'b110; clear_store();
        data_in = 16'h0000; step(2);
        data_in = 16'h0003; step(2); chk("R8 J sets", periph_out, 1'b1);
        data_in = 16'h0000; step(1);
        data_in = 16'h0001; step(2); chk("R8 neither holds", periph_out, 1'b1);
        data_in = 16'h0000; step(1);
        data_in = 16'h0009; step(2); chk("R8 K clears", periph_out, 1'b0);
        data_in = 16'h0000; step(1);
        data_in = 16'h000B; step(2); chk("R8 toggle up", periph_out, 1'b1);
        data_in = 16'h0000; step(1);
        data_in = 16'h000B; step(2); chk("R8 toggle down", periph_out, 1'b0);
        data_in = 16'h0000; step(1);
        data_in = 16'h0003; step(2);
        data_in = 16'h0006; step(2); chk("R8 reset", periph_out, 1'b0);
        data_in = 16'h0000;
    endtask

    task automatic t_tlat_R9();
        gates_direct(); mode = 3'b111; clear_store();
        data_in = 16'h0000; step(2); chk("R9 pass low", periph_out, 1'b0);
        data_in = 16'h0002; step(2); chk("R9 pass high", periph_out, 1'b1);
        data_in = 16'h0006; step(2); chk("R9 closed holds", periph_out, 1'b1);
        data_in = 16'h0004; step(2); chk("R9 closed ignores D", periph_out, 1'b1);
        data_in = 16'h0000; step(2); chk("R9 reopen follows", periph_out, 1'b0);
        data_in = 16'h000C; step(2); chk("R9 set", periph_out, 1'b1);
        data_in = 16'h0005; step(2); chk("R9 reset", periph_out, 1'b0);
        data_in = 16'h000A; step(2); chk("R9 set again", periph_out, 1'b1);
        data_in = 16'h000B; step(2); chk("R9 reset wins", periph_out, 1'b0);
        data_in = 16'h0000;
    endtask

    task automatic t_pol_en_R10();
        cell_en = 1'b1;
        gates_follow_d0();
        out_pol = 1'b1;
        data_in = 16'h0000; step(1); chk("R10 inverted 0", periph_out, 1'b1);
        data_in = 16'h0001; step(1); chk("R10 inverted 1", periph_out, 1'b0);
        data_in = 16'h0000; cell_en = 1'b0; step(1);
        chk("R10 disabled low despite polarity", periph_out, 1'b0);
        out_pol = 1'b0;
        gates_direct(); mode = 3'b011; cell_en = 1'b1;
        data_in = 16'h0001; step(2);
        data_in = 16'h0000; step(1);
        chk("R10 store set before disable", periph_out, 1'b1);
        cell_en = 1'b0; step(2);
        cell_en = 1'b1; step(2);
        chk("R10 disable clears store", periph_out, 1'b0);
    endtask

    task automatic t_pin_R11();
        cell_en = 1'b1;
        gates_follow_d0();
        out_pol = 1'b0;
        pin_oe = 1'b0;
        data_in = 16'h0001; step(1);
        chk("R11 pin off", pin_out, 1'b0);
        pin_oe = 1'b1; #0.5;
        chk("R11 pin on", pin_out, 1'b1);
        data_in = 16'h0000; step(1);
        chk("R11 pin follows low", pin_out, 1'b0);
        pin_oe = 1'b0;
    endtask

    task automatic t_irq_R13();
        cell_en = 1'b1;
        gates_follow_d0();
        irq_pos_en = 1'b1; irq_neg_en = 1'b0;
        data_in = 16'h0000; step(2);
        irq_clr = 1'b1; step(1); irq_clr = 1'b0;
        data_in = 16'h0001; step(1);
        chk("R13 flag not yet", irq_flag, 1'b0);
        step(1);
        chk("R13 rise sets flag", irq_flag, 1'b1);
        data_in = 16'h0000; step(3);
        chk("R13 flag sticky", irq_flag, 1'b1);
        irq_clr = 1'b1; step(1); irq_clr = 1'b0;
        chk("R13 clear drops flag", irq_flag, 1'b0);
        irq_pos_en = 1'b0; irq_neg_en = 1'b1;
        data_in = 16'h0001; step(3);
        chk("R13 rise ignored when only fall enabled", irq_flag, 1'b0);
        data_in = 16'h0000; step(2);
        chk("R13 fall sets flag", irq_flag, 1'b1);
        irq_clr = 1'b1; step(1); irq_clr = 1'b0;
        irq_pos_en = 1'b1; irq_neg_en = 1'b0;
        step(1);
        data_in = 16'h0001; step(1);
        irq_clr = 1'b1; step(1); irq_clr = 1'b0;
        chk("R13 set wins over clear", irq_flag, 1'b1);
        irq_pos_en = 1'b0;
        data_in = 16'h0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_gates_R1();
        t_comb(0, "R2 and-or");
        t_comb(1, "R3 or-xor");
        t_comb(2, "R4 and4");
        t_latency_R12();
        t_sr_R5();
        t_dff_R6();
        t_dffr_R7();
        t_jk_R8();
        t_tlat_R9();
        t_pol_en_R10();
        t_pin_R11();
        t_irq_R13();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule